// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block collects a vector of level-sensitive interrupt sources and produces two request lines toward a processor. One is a normal interrupt request and the other is a fast interrupt request. Both outputs look at the same raw level vector. Each output has its own enable mask, so a source can be steered to the normal line, to the fast line, to both, or to neither. A software-controlled bit is ORed into source 0. Firmware can therefore raise an interrupt without any external stimulus.

Software reaches the block through a word-indexed register port. A read is requested by a pulse on the read strobe, and the data is returned one clock later. Each mask has two write paths: one sets the bits written as 1, and the other clears them. Both masked status and raw status can be read. A status word cannot be written, and a clear word cannot be read; either access is an illegal access, as is any access to an unused word. An illegal access returns zero or changes nothing, and it raises a one-cycle error pulse.

Two instances can be cascaded by wiring the request output of one into a source input of the other. The block does no priority encoding and produces no vector.

Top module: `intc_dual`

## Requirements
- R1: Raw level bit n equals source input n, and bit 0 is additionally ORed with the software bit. The raw level reads back at word 1 and at word 9.
- R2: Word 0 reads the raw level ANDed with the normal enable mask. Word 8 reads the raw level ANDed with the fast enable mask.
- R3: A write to word 2 ORs the data into the normal enable mask. A write to word 3 clears every normal enable bit written as 1. Word 2 reads back the normal mask.
- R4: A write to word 10 ORs the data into the fast enable mask. A write to word 11 clears every fast enable bit written as 1. Word 10 reads back the fast mask.
- R5: Writing word 4 with bit 0 = 1 sets the software bit, and writing word 5 with bit 0 = 1 clears it. Writes with bit 0 = 0 leave the software bit unchanged. Word 4 reads raw level bit 0, zero-extended.
- R6: `irq_o` is the OR of (raw level AND normal mask), and `fiq_o` is the OR of (raw level AND fast mask). Each is registered, so a change in a source or a mask appears on the output after exactly one clock edge.
- R7: The illegal reads are words 3, 5 and 11 and any unused word (6, 7, 12 to 15). These return 0. The illegal writes are words 0, 1, 8 and 9 and any unused word. These change neither mask nor the software bit.
- R8: `err_o` is high for exactly the one cycle after each illegal read or write, and low after any cycle that contains no illegal access.
- R9: After reset, both masks and the software bit are 0, and `irq_o`, `fiq_o`, `err_o` and `rdata_o` are 0.
- R10: Read data appears on `rdata_o` in the cycle after `rd_en_i`. In the cycle after a clock with no read, `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Level-sensitive source inputs |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Word index |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| err_o | output | 1 | Illegal access pulse |

## Verification
The bench builds the block with NUM_SRC = 8, keeping DATA_W = 32 and ADDR_W = 4. At this size every word index can be read and written in turn. All 256 source patterns can also be swept against fixed masks while the bench computes each expected request level arithmetically. With the narrow source vector, the bench can also check that the upper data bits are zero-extended on reads and ignored on writes.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int W_IRQ_STAT = 0;
    localparam int W_IRQ_RAW  = 1;
    localparam int W_IRQ_SET  = 2;
    localparam int W_IRQ_CLR  = 3;
    localparam int W_SW_SET   = 4;
    localparam int W_SW_CLR   = 5;
    localparam int W_FIQ_STAT = 8;
    localparam int W_FIQ_RAW  = 9;
    localparam int W_FIQ_SET  = 10;
    localparam int W_FIQ_CLR  = 11;

    localparam int NUM_OUT = 2;   // index 0: normal line, index 1: fast line

    typedef struct packed {
        logic [NUM_OUT-1:0] set_we;
        logic [NUM_OUT-1:0] clr_we;
        logic               sw_set;
        logic               sw_clr;
        logic               rd_ok;
        logic               wr_ok;
    } dec_t;
endpackage

// File: rtl/intc_decode.sv
module intc_decode
    import intc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    output dec_t              dec_o
);
    always_comb begin
        dec_o = '0;
        case (int'(addr_i))
            W_IRQ_STAT, W_IRQ_RAW, W_FIQ_STAT, W_FIQ_RAW: dec_o.rd_ok = 1'b1;
            W_IRQ_SET: begin
                dec_o.rd_ok     = 1'b1;
                dec_o.wr_ok     = 1'b1;
                dec_o.set_we[0] = wr_en_i;
            end
            W_FIQ_SET: begin
                dec_o.rd_ok     = 1'b1;
                dec_o.wr_ok     = 1'b1;
                dec_o.set_we[1] = wr_en_i;
            end
            W_IRQ_CLR: begin
                dec_o.wr_ok     = 1'b1;
                dec_o.clr_we[0] = wr_en_i;
            end
            W_FIQ_CLR: begin
                dec_o.wr_ok     = 1'b1;
                dec_o.clr_we[1] = wr_en_i;
            end
            W_SW_SET: begin
                dec_o.rd_ok  = 1'b1;
                dec_o.wr_ok  = 1'b1;
                dec_o.sw_set = wr_en_i;
            end
            W_SW_CLR: begin
                dec_o.wr_ok  = 1'b1;
                dec_o.sw_clr = wr_en_i;
            end
            default: ;
        endcase
        if (!rd_en_i && !wr_en_i) begin
            dec_o.rd_ok = 1'b0;
            dec_o.wr_ok = 1'b0;
        end
    end
endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               set_we_i,
    input  logic               clr_we_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] mask_d_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_we_i) st_d.mask = st_q.mask | wdata_i;
        if (clr_we_i) st_d.mask = st_q.mask & ~wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign mask_o   = st_q.mask;
    assign mask_d_o = st_d.mask;

    AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_we_i |=> ((mask_o & $past(wdata_i)) == $past(wdata_i))); // R3
    AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_we_i && !set_we_i) |=> ((mask_o & $past(wdata_i)) == '0)); // R3
    AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!set_we_i && !clr_we_i) |=> $stable(mask_o)); // R7
endmodule

// File: rtl/intc_dual.sv
module intc_dual
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               rd_en_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               irq_o,
    output logic               fiq_o,
    output logic               err_o
);
    localparam int PAD_W = DATA_W - NUM_SRC;

    typedef struct packed {
        logic              sw;
        logic              irq;
        logic              fiq;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;
    dec_t    dec;

    logic [NUM_SRC-1:0] en_q [NUM_OUT];
    logic [NUM_SRC-1:0] en_d [NUM_OUT];
    logic [NUM_SRC-1:0] lvl_now, lvl_next;
    logic [NUM_SRC-1:0] sw_vec_q, sw_vec_d;

    intc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i  (addr_i),
        .rd_en_i (rd_en_i),
        .wr_en_i (wr_en_i),
        .dec_o   (dec)
    );

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_mask
        intc_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .set_we_i (dec.set_we[k]),
            .clr_we_i (dec.clr_we[k]),
            .wdata_i  (wdata_i[NUM_SRC-1:0]),
            .mask_o   (en_q[k]),
            .mask_d_o (en_d[k])
        );
    end

    function automatic logic [DATA_W-1:0] widen(input logic [NUM_SRC-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[NUM_SRC-1:0] = v;
        return r;
    endfunction

    always_comb begin
        sw_vec_q    = '0;
        sw_vec_q[0] = st_q.sw;
        lvl_now     = src_i | sw_vec_q;
    end

    always_comb begin
        st_d = st_q;
        if (dec.sw_set && wdata_i[0]) st_d.sw = 1'b1;
        if (dec.sw_clr && wdata_i[0]) st_d.sw = 1'b0;

        sw_vec_d    = '0;
        sw_vec_d[0] = st_d.sw;
        lvl_next    = src_i | sw_vec_d;
        st_d.irq    = |(lvl_next & en_d[0]);
        st_d.fiq    = |(lvl_next & en_d[1]);

        st_d.err = (rd_en_i && !dec.rd_ok) || (wr_en_i && !dec.wr_ok);

        st_d.rdata = '0;
        if (rd_en_i) begin
            case (int'(addr_i))
                W_IRQ_STAT:           st_d.rdata = widen(lvl_now & en_q[0]);
                W_FIQ_STAT:           st_d.rdata = widen(lvl_now & en_q[1]);
                W_IRQ_RAW, W_FIQ_RAW: st_d.rdata = widen(lvl_now);
                W_IRQ_SET:            st_d.rdata = widen(en_q[0]);
                W_FIQ_SET:            st_d.rdata = widen(en_q[1]);
                W_SW_SET:             st_d.rdata = DATA_W'(lvl_now[0]);
                default:              st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;
    assign irq_o   = st_q.irq;
    assign fiq_o   = st_q.fiq;
    assign err_o   = st_q.err;

    AST_BAD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && !wr_en_i && !dec.rd_ok) |=> (rdata_o == '0)); // R7
    AST_ERR_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rd_en_i && !dec.rd_ok) || (wr_en_i && !dec.wr_ok)) |=> err_o); // R8
    AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_en_i && !wr_en_i) |=> !err_o); // R8
    AST_SW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && int'(addr_i) == W_SW_SET && wdata_i[0]) |=> st_q.sw); // R5
    AST_NO_MASK_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_q[0] == '0) |-> !irq_o); // R6
    AST_NO_MASK_NO_FIQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_q[1] == '0) |-> !fiq_o); // R6
    AST_IDLE_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> (rdata_o == '0)); // R10
    if (PAD_W > 0) begin : g_pad_chk
        AST_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rdata_o[DATA_W-1:NUM_SRC] == '0); // R1
    end
endmodule

// File: tb/sim_intc_dual.sv
module sim_intc_dual;
    localparam int N  = 8;
    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src = '0;
    logic          rd_en = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq, fiq, err;

    int checks = 0, failures = 0;
    logic [N-1:0] m_irq = '0, m_fiq = '0;
    logic         m_sw = 1'b0;

    always #5 clk = ~clk;

    intc_dual #(.NUM_SRC(N), .DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .rd_en_i(rd_en),
        .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq), .err_o(err)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit rd_legal(input int a);
        return a inside {0, 1, 2, 4, 8, 9, 10};
    endfunction
    function automatic bit wr_legal(input int a);
        return a inside {2, 3, 4, 5, 10, 11};
    endfunction
    function automatic logic [N-1:0] lvl();
        return src | {{(N-1){1'b0}}, m_sw};
    endfunction
    function automatic logic [DW-1:0] exp_rd(input int a);
        case (a)
            0:       return DW'(lvl() & m_irq);
            8:       return DW'(lvl() & m_fiq);
            1, 9:    return DW'(lvl());
            2:       return DW'(m_irq);
            10:      return DW'(m_fiq);
            4:       return DW'(lvl()[0]);
            default: return '0;
        endcase
    endfunction

    task automatic rd(input int a, input string req);
        logic [DW-1:0] e;
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b0; addr = AW'(a);
        e = exp_rd(a);
        @(posedge clk); #1;
        chk(rdata == e, req, rdata, e);
        chk(err == !rd_legal(a), "R8", DW'(err), DW'(!rd_legal(a)));
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b0; addr = AW'(a); wdata = d;
        if (wr_legal(a)) begin
            case (a)
                2:  m_irq = m_irq | d[N-1:0];
                3:  m_irq = m_irq & ~d[N-1:0];
                10: m_fiq = m_fiq | d[N-1:0];
                11: m_fiq = m_fiq & ~d[N-1:0];
                4:  if (d[0]) m_sw = 1'b1;
                5:  if (d[0]) m_sw = 1'b0;
                default: ;
            endcase
        end
        @(posedge clk); #1;
        chk(err == !wr_legal(a), "R8", DW'(err), DW'(!wr_legal(a)));
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic set_src(input logic [N-1:0] v);
        @(negedge clk); src = v;
        @(posedge clk); #1;
    endtask

    task automatic chk_out(input string req);
        logic ei, ef;
        ei = |(lvl() & m_irq);
        ef = |(lvl() & m_fiq);
        chk(irq == ei, req, DW'(irq), DW'(ei));
        chk(fiq == ef, req, DW'(fiq), DW'(ef));
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        chk(irq == 0 && fiq == 0 && err == 0 && rdata == 0, "R9",
            {rdata[DW-4:0], irq, fiq, err}, '0);
        @(negedge clk); rst_n = 1'b1;
        rd(2, "R9"); rd(10, "R9"); rd(4, "R9");
        @(posedge clk); #1;
        chk(err == 0, "R8", DW'(err), 0);
        chk(rdata == 0, "R10", rdata, 0);

        // R3 R4: set masks (upper data bits beyond N ignored)
        wr(2, 32'hFFFF_FF3C);
        wr(10, 32'h0000_00C3);
        set_src(8'hA5);
        chk_out("R6");
        // read sweep: R1 R2 R7 R10
        for (int a = 0; a < 16; a++) rd(a, "R1_R2_R7");

        // R7: illegal writes leave state untouched
        set_src(8'hA4);
        for (int a = 0; a < 16; a++) begin
            if (!wr_legal(a)) begin
                wr(a, 32'hFFFF_FFFF);
                rd(2, "R7"); rd(10, "R7"); rd(4, "R7");
            end
        end

        // R3 R4 clear paths
        wr(3, 32'h0000_000C);
        rd(2, "R3");
        wr(11, 32'h0000_0003);
        rd(10, "R4");
        chk_out("R6");

        // R5 software bit
        set_src(8'h00);
        wr(4, 32'h0000_00FE);
        rd(4, "R5");
        wr(4, 32'h0000_0001);
        rd(4, "R5"); rd(1, "R1"); rd(9, "R1");
        wr(2, 32'h0000_0001);
        chk_out("R6");
        chk(irq == 1'b1, "R5", DW'(irq), 1);
        wr(5, 32'h0000_00FE);
        rd(4, "R5");
        wr(5, 32'h0000_0001);
        chk_out("R6");
        rd(0, "R2");

        // R6 full source sweep
        for (int v = 0; v < 256; v++) begin
            set_src(N'(v));
            chk_out("R6");
        end
        rd(8, "R2");
        @(posedge clk); #1;
        chk(err == 0, "R8", DW'(err), 0);
        chk(rdata == 0, "R10", rdata, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule